// File: doc/BRIEF.md
# Permutation-Coded LRU Order Tracker

This block holds the complete least-recently-used order of the ways of a set-associative cache, one entry per line index. Each entry is a small code that names a single permutation of the ways, read from the least recently used way to the most recently used one. The way count is 2, 3 or 4, set by a parameter, and the number of line indexes is a power-of-two parameter.

When the cache reports a hit or a fill on some way of some index, the update port names that index and way. On the next clock edge the stored code changes so that the named way becomes the most recently used one, and the other ways keep their relative order. A separate query port takes an index and returns, combinationally, the stored code and the way that a refill should evict. Tags, data, hit detection and way locking belong to the surrounding cache.

Top module: `lru_perm_tracker`

## Requirements
- R1: After reset every index holds code 0, the identity order (way 0 least recent, highest way most recent), and the query port reports victim way 0 for every index.
- R2: The code is 1 bit wide for 2 ways, 3 bits for 3 ways and 5 bits for 4 ways. For 3 and 4 ways, codes 0 upward number the permutations of the ways in ascending lexicographic order of the LRU-to-MRU sequence (3 ways: 0=012, 1=021, 2=102, 3=120, 4=201, 5=210; 4 ways: 0=0123, 1=0132, ... 23=3210). For 2 ways the bit is the number of the least recently used way.
- R3: An accepted access to way N takes N out of the order and places it at the most recent end, leaving the other ways in their relative order (3 ways: code 0 accessed on way 0 gives code 3; 4 ways: code 0 accessed on way 1 gives code 3).
- R4: An accepted access to the way that is already the most recent leaves the code unchanged.
- R5: The reported victim is the first (least recently used) way of the order the stored code names.
- R6: Codes that name no permutation are updated as if they held the all-descending order (3 ways: codes 6 and 7 act as 210; 4 ways: codes 24 to 31 act as 3210). Their victim is way 2 with 3 ways and way 0 with 4 ways.
- R7: An accepted update is written at the next rising clock edge; a query of the same index in the update cycle returns the old code, and entries of other indexes do not change.
- R8: An update with upd_valid_i low, or with a way number at or above the configured way count, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Access report valid |
| upd_index_i | input | IDX_W = log2(NUM_SETS) | Line index of the access |
| upd_way_i | input | 2 | Way that was accessed |
| qry_index_i | input | IDX_W | Line index to query |
| victim_o | output | 2 | Least recently used way of the queried index |
| qry_code_o | output | STATE_W (1, 3 or 5) | Stored order code of the queried index |

## Verification
The bench sweeps every code and every way through the update and victim logic for 3 and 4 ways, including the unused codes, so a design that mis-ordered the lexicographic numbering, dropped a way while rotating, or reported the wrong victim for an unused code shows a code or way that differs from the value worked out from an enumerated permutation list. Three full trackers of 2, 3 and 4 ways then take a long run of pseudo-random accesses against ordered-list models; an update written a cycle early shows as a changed code during the update cycle, a write landing on the wrong index shows on a neighbouring query, and a tracker that accepted out-of-range way numbers shows a moved order on the 2- and 3-way instances.

// File: rtl/lru_perm_pkg.sv
package lru_perm_pkg;

  localparam int MAX_WAYS = 4;
  localparam int WAY_W    = 2;
  localparam int CODE_W   = 5;

  typedef logic [WAY_W-1:0]        way_t;
  typedef logic [CODE_W-1:0]       code_t;
  typedef way_t [MAX_WAYS-1:0]     order_t;  // element 0 = least recent

  function automatic int fact(int n);
    int r;
    r = 1;
    for (int i = 2; i <= MAX_WAYS; i++) begin
      if (i <= n) r = r * i;
    end
    return r;
  endfunction

  function automatic int state_width(int n);
    if (n <= 2) return 1;
    if (n == 3) return 3;
    return 5;
  endfunction

  // Factorial-base digits pick the k-th still unused way at each position.
  function automatic order_t code_to_order(int n, code_t code);
    order_t               ord;
    logic [MAX_WAYS-1:0]  used;
    int                   rem;
    int                   wgt;
    int                   dig;
    int                   seen;
    ord  = '0;
    used = '0;
    rem  = int'(code);
    if (rem >= fact(n)) rem = fact(n) - 1;  // unused codes act as all-descending
    for (int pos = 0; pos < MAX_WAYS; pos++) begin
      if (pos < n) begin
        wgt  = fact(n - 1 - pos);
        dig  = rem / wgt;
        rem  = rem % wgt;
        seen = 0;
        for (int k = 0; k < MAX_WAYS; k++) begin
          if (k < n && !used[way_t'(k)]) begin
            if (seen == dig) begin
              ord[way_t'(pos)] = way_t'(k);
              used[way_t'(k)]  = 1'b1;
            end
            seen++;
          end
        end
      end
    end
    return ord;
  endfunction

  function automatic code_t order_to_code(int n, order_t ord);
    int acc;
    int smaller;
    acc = 0;
    for (int pos = 0; pos < MAX_WAYS; pos++) begin
      if (pos < n) begin
        smaller = 0;
        for (int q = 0; q < MAX_WAYS; q++) begin
          if (q > pos && q < n && ord[way_t'(q)] < ord[way_t'(pos)]) smaller++;
        end
        acc = acc + smaller * fact(n - 1 - pos);
      end
    end
    return code_t'(acc);
  endfunction

  function automatic order_t touch_order(int n, order_t ord, way_t w);
    order_t nxt;
    int     j;
    nxt = '0;
    j   = 0;
    for (int pos = 0; pos < MAX_WAYS; pos++) begin
      if (pos < n && ord[way_t'(pos)] != w && j < n - 1) begin
        nxt[way_t'(j)] = ord[way_t'(pos)];
        j++;
      end
    end
    nxt[way_t'(n - 1)] = w;
    return nxt;
  endfunction

endpackage

// File: rtl/lru_code_update.sv
module lru_code_update
  import lru_perm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int STATE_W  = state_width(NUM_WAYS)
) (
  input  logic [STATE_W-1:0] cur_code_i,
  input  logic [WAY_W-1:0]   way_i,
  output logic [STATE_W-1:0] nxt_code_o
);

  order_t cur_ord;
  order_t nxt_ord;
  code_t  nxt_full;

  always_comb begin
    cur_ord    = code_to_order(NUM_WAYS, code_t'(cur_code_i));
    nxt_ord    = touch_order(NUM_WAYS, cur_ord, way_i);
    nxt_full   = order_to_code(NUM_WAYS, nxt_ord);
    nxt_code_o = nxt_full[STATE_W-1:0];
  end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
  import lru_perm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int STATE_W  = state_width(NUM_WAYS)
) (
  input  logic [STATE_W-1:0] code_i,
  output logic [WAY_W-1:0]   victim_o
);

  localparam int NUM_CODES = fact(NUM_WAYS);

  order_t ord;

  always_comb ord = code_to_order(NUM_WAYS, code_t'(code_i));

  generate
    if (NUM_WAYS == 4) begin : g_wide
      // unused 4-way codes evict way 0
      always_comb victim_o = (int'(code_i) >= NUM_CODES) ? '0 : ord[0];
    end else begin : g_narrow
      always_comb victim_o = ord[0];
    end
  endgenerate

endmodule

// File: rtl/lru_state_store.sv
module lru_state_store #(
  parameter int NUM_SETS = 64,
  parameter int STATE_W  = 5,
  parameter int IDX_W    = $clog2(NUM_SETS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [STATE_W-1:0] wr_code_i,
  input  logic [IDX_W-1:0]   rd_a_idx_i,
  output logic [STATE_W-1:0] rd_a_code_o,
  input  logic [IDX_W-1:0]   rd_b_idx_i,
  output logic [STATE_W-1:0] rd_b_code_o
);

  logic [STATE_W-1:0] mem_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) mem_q[s] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_code_i;
    end
  end

  assign rd_a_code_o = mem_q[rd_a_idx_i];
  assign rd_b_code_o = mem_q[rd_b_idx_i];

endmodule

// File: rtl/lru_perm_tracker.sv
module lru_perm_tracker
  import lru_perm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 64,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int STATE_W = state_width(NUM_WAYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_valid_i,
  input  logic [IDX_W-1:0]   upd_index_i,
  input  logic [1:0]         upd_way_i,
  input  logic [IDX_W-1:0]   qry_index_i,
  output logic [1:0]         victim_o,
  output logic [STATE_W-1:0] qry_code_o
);

  logic               upd_ok;
  logic [STATE_W-1:0] upd_cur_code;
  logic [STATE_W-1:0] upd_nxt_code;

  assign upd_ok = upd_valid_i && (int'(upd_way_i) < NUM_WAYS);

  lru_state_store #(
    .NUM_SETS (NUM_SETS),
    .STATE_W  (STATE_W),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (upd_ok),
    .wr_idx_i    (upd_index_i),
    .wr_code_i   (upd_nxt_code),
    .rd_a_idx_i  (upd_index_i),
    .rd_a_code_o (upd_cur_code),
    .rd_b_idx_i  (qry_index_i),
    .rd_b_code_o (qry_code_o)
  );

  lru_code_update #(
    .NUM_WAYS (NUM_WAYS),
    .STATE_W  (STATE_W)
  ) u_upd (
    .cur_code_i (upd_cur_code),
    .way_i      (upd_way_i),
    .nxt_code_o (upd_nxt_code)
  );

  lru_victim_pick #(
    .NUM_WAYS (NUM_WAYS),
    .STATE_W  (STATE_W)
  ) u_vic (
    .code_i   (qry_code_o),
    .victim_o (victim_o)
  );

endmodule

// File: rtl/lru_perm_tracker_chk.sv
module lru_perm_tracker_chk
  import lru_perm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 64,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int STATE_W = state_width(NUM_WAYS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               upd_valid_i,
  input logic [IDX_W-1:0]   upd_index_i,
  input logic [1:0]         upd_way_i,
  input logic [IDX_W-1:0]   qry_index_i,
  input logic [1:0]         victim_o,
  input logic [STATE_W-1:0] qry_code_o
);

  localparam int NUM_CODES = fact(NUM_WAYS);

  logic acc_ok;
  assign acc_ok = upd_valid_i && (int'(upd_way_i) < NUM_WAYS);

  a_r2_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(qry_code_o) < NUM_CODES);

  a_r5_victim_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(victim_o) < NUM_WAYS);

  a_r3_touched_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && (qry_index_i == upd_index_i) |=>
      (qry_index_i != $past(qry_index_i)) || (victim_o != $past(upd_way_i)));

  a_r8_ignored_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ok |=> (qry_index_i != $past(qry_index_i)) || $stable(qry_code_o));

  a_r7_other_index_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && (qry_index_i != upd_index_i) |=>
      (qry_index_i != $past(qry_index_i)) || $stable(qry_code_o));

  a_r4_repeat_is_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && $past(acc_ok) && (upd_index_i == $past(upd_index_i)) &&
    (upd_way_i == $past(upd_way_i)) && (qry_index_i == upd_index_i) |=>
      (qry_index_i != $past(qry_index_i)) || $stable(qry_code_o));

endmodule

bind lru_perm_tracker lru_perm_tracker_chk #(
  .NUM_WAYS (NUM_WAYS),
  .NUM_SETS (NUM_SETS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_index_i (upd_index_i),
  .upd_way_i   (upd_way_i),
  .qry_index_i (qry_index_i),
  .victim_o    (victim_o),
  .qry_code_o  (qry_code_o)
);

// File: tb/lru_perm_tracker_tb.sv
`timescale 1ns/1ps
module lru_perm_tracker_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_valid = 1'b0;
  logic [2:0] upd_idx = '0;
  logic [1:0] upd_way = '0;
  logic [2:0] qry_idx = '0;
  logic [1:0] vic4, vic3, vic2;
  logic [4:0] code4;
  logic [2:0] code3;
  logic [0:0] code2;

  logic [4:0] sw_code4 = '0;
  logic [2:0] sw_code3 = '0;
  logic [1:0] sw_way = '0;
  logic [4:0] sw_nxt4;
  logic [2:0] sw_nxt3;
  logic [1:0] sw_vic4, sw_vic3;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lru_perm_tracker #(.NUM_WAYS(4), .NUM_SETS(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd_valid), .upd_index_i(upd_idx),
    .upd_way_i(upd_way), .qry_index_i(qry_idx), .victim_o(vic4), .qry_code_o(code4));
  lru_perm_tracker #(.NUM_WAYS(3), .NUM_SETS(4)) u_dut3 (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd_valid), .upd_index_i(upd_idx[1:0]),
    .upd_way_i(upd_way), .qry_index_i(qry_idx[1:0]), .victim_o(vic3), .qry_code_o(code3));
  lru_perm_tracker #(.NUM_WAYS(2), .NUM_SETS(4)) u_dut2 (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd_valid), .upd_index_i(upd_idx[1:0]),
    .upd_way_i(upd_way), .qry_index_i(qry_idx[1:0]), .victim_o(vic2), .qry_code_o(code2));

  lru_code_update #(.NUM_WAYS(4)) u_upd4 (.cur_code_i(sw_code4), .way_i(sw_way), .nxt_code_o(sw_nxt4));
  lru_victim_pick #(.NUM_WAYS(4)) u_vic4 (.code_i(sw_code4), .victim_o(sw_vic4));
  lru_code_update #(.NUM_WAYS(3)) u_upd3 (.cur_code_i(sw_code3), .way_i(sw_way), .nxt_code_o(sw_nxt3));
  lru_victim_pick #(.NUM_WAYS(3)) u_vic3 (.code_i(sw_code3), .victim_o(sw_vic3));

  int p4[24][4];
  int p3[6][3];
  int m4[8][4];
  int m3[4][3];
  int m2[4];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enc4(int a, int b, int c, int d);
    for (int k = 0; k < 24; k++)
      if (p4[k][0] == a && p4[k][1] == b && p4[k][2] == c && p4[k][3] == d) return k;
    return -1;
  endfunction

  function automatic int enc3(int a, int b, int c);
    for (int k = 0; k < 6; k++)
      if (p3[k][0] == a && p3[k][1] == b && p3[k][2] == c) return k;
    return -1;
  endfunction

  function automatic int touch4(int k, int w);
    int t[4];
    int j = 0;
    for (int p = 0; p < 4; p++) if (p4[k][p] != w) begin t[j] = p4[k][p]; j++; end
    t[3] = w;
    return enc4(t[0], t[1], t[2], t[3]);
  endfunction

  function automatic int touch3(int k, int w);
    int t[3];
    int j = 0;
    for (int p = 0; p < 3; p++) if (p3[k][p] != w) begin t[j] = p3[k][p]; j++; end
    t[2] = w;
    return enc3(t[0], t[1], t[2]);
  endfunction

  function automatic int mcode4(int i);
    return enc4(m4[i][0], m4[i][1], m4[i][2], m4[i][3]);
  endfunction

  function automatic int mcode3(int i);
    return enc3(m3[i][0], m3[i][1], m3[i][2]);
  endfunction

  task automatic check_idx(string req, int i);
    qry_idx = 3'(i);
    #1;
    chk({req, " 4-way code"}, int'(code4), mcode4(i));
    chk({req, " 4-way victim R5"}, int'(vic4), m4[i][0]);
    chk({req, " 3-way code"}, int'(code3), mcode3(i % 4));
    chk({req, " 3-way victim R5"}, int'(vic3), m3[i % 4][0]);
    chk({req, " 2-way code"}, int'(code2), m2[i % 4]);
    chk({req, " 2-way victim R5"}, int'(vic2), m2[i % 4]);
  endtask

  task automatic model_touch(int i, int w);
    int t[4];
    int j = 0;
    for (int p = 0; p < 4; p++) if (m4[i][p] != w) begin t[j] = m4[i][p]; j++; end
    t[3] = w;
    for (int p = 0; p < 4; p++) m4[i][p] = t[p];
    if (w < 3) begin
      j = 0;
      for (int p = 0; p < 3; p++) if (m3[i % 4][p] != w) begin t[j] = m3[i % 4][p]; j++; end
      t[2] = w;
      for (int p = 0; p < 3; p++) m3[i % 4][p] = t[p];
    end
    if (w < 2) m2[i % 4] = 1 - w;
  endtask

  // R7: old value visible in the update cycle, new value after the edge
  task automatic access(int i, int w, string req);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_idx   = 3'(i);
    upd_way   = 2'(w);
    qry_idx   = 3'(i);
    #1;
    chk("R7 old code during update 4-way", int'(code4), mcode4(i));
    chk("R7 old code during update 3-way", int'(code3), mcode3(i % 4));
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    model_touch(i, w);
    check_idx(req, i);
  endtask

  initial begin
    int n;
    n = 0;
    for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++)
      for (int c = 0; c < 4; c++) for (int d = 0; d < 4; d++)
        if (a != b && a != c && a != d && b != c && b != d && c != d) begin
          p4[n][0] = a; p4[n][1] = b; p4[n][2] = c; p4[n][3] = d; n++;
        end
    n = 0;
    for (int a = 0; a < 3; a++) for (int b = 0; b < 3; b++) for (int c = 0; c < 3; c++)
      if (a != b && a != c && b != c) begin
        p3[n][0] = a; p3[n][1] = b; p3[n][2] = c; n++;
      end
    for (int i = 0; i < 8; i++) for (int p = 0; p < 4; p++) m4[i][p] = p;
    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < 3; p++) m3[i][p] = p;
      m2[i] = 0;
    end

    // combinational sweeps over every code and way
    for (int c = 0; c < 32; c++) begin
      for (int w = 0; w < 4; w++) begin
        int k;
        sw_code4 = 5'(c);
        sw_way   = 2'(w);
        #1;
        k = (c > 23) ? 23 : c;
        if (c > 23) begin
          chk("R6 4-way unused code update", int'(sw_nxt4), touch4(23, w));
          chk("R6 4-way unused code victim", int'(sw_vic4), 0);
        end else if (p4[c][3] == w) begin
          chk("R4 4-way MRU access keeps code", int'(sw_nxt4), c);
          chk("R5 4-way victim", int'(sw_vic4), p4[c][0]);
        end else begin
          chk("R3 4-way move to MRU", int'(sw_nxt4), touch4(k, w));
          chk("R5 4-way victim", int'(sw_vic4), p4[c][0]);
        end
      end
    end
    for (int c = 0; c < 8; c++) begin
      for (int w = 0; w < 3; w++) begin
        sw_code3 = 3'(c);
        sw_way   = 2'(w);
        #1;
        if (c > 5) begin
          chk("R6 3-way unused code update", int'(sw_nxt3), touch3(5, w));
          chk("R6 3-way unused code victim", int'(sw_vic3), 2);
        end else if (p3[c][2] == w) begin
          chk("R4 3-way MRU access keeps code", int'(sw_nxt3), c);
          chk("R5 3-way victim", int'(sw_vic3), p3[c][0]);
        end else begin
          chk("R3 3-way move to MRU", int'(sw_nxt3), touch3(c, w));
          chk("R5 3-way victim", int'(sw_vic3), p3[c][0]);
        end
      end
    end
    sw_code3 = 3'd0; sw_way = 2'd0; #1;
    chk("R3 3-way 012 on way 0 gives 120", int'(sw_nxt3), 3);
    sw_code4 = 5'd0; sw_way = 2'd1; #1;
    chk("R3 4-way 0123 on way 1 gives 0231", int'(sw_nxt4), 3);

    // reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_idx("R1 reset", i);
    end

    // descending fill gives the last code
    access(2, 3, "R2 fill");
    access(2, 2, "R2 fill");
    access(2, 1, "R2 fill");
    access(2, 0, "R2 fill");
    qry_idx = 3'd2; #1;
    chk("R2 4-way 3210 is code 23", int'(code4), 23);
    chk("R2 3-way 210 is code 5", int'(code3), 5);
    chk("R2 2-way LRU bit is way 1", int'(code2), 1);
    access(2, 0, "R4 repeat");
    chk("R4 repeat keeps 4-way code", int'(code4), 23);

    // out-of-range ways on the narrow trackers
    access(5, 3, "R8 way 3");
    access(6, 2, "R8 way 2");

    // valid low: nothing written
    @(negedge clk);
    upd_valid = 1'b0; upd_idx = 3'd2; upd_way = 2'd3;
    @(posedge clk); #1;
    check_idx("R8 valid low", 2);

    // random run
    for (int r = 0; r < 1500; r++) begin
      int i = int'($urandom % 8);
      int w = int'($urandom % 4);
      access(i, w, "R3 random");
      check_idx("R7 other index", int'($urandom % 8));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule